// File: doc/BRIEF.md
# Quad-Rail Undervoltage/Overvoltage Fault Sequencer

This block turns comparator decisions from four supervised supply rails into two shared, registered, active-low fault outputs: one for undervoltage and one for overvoltage. Each rail provides two digital flags. One says the high divider tap is below its threshold. The other says the low divider tap is above its threshold. Every flag must hold the same value for `NCHK` consecutive clock samples before the block uses it.

Rails 1 and 2 are always positive supplies. A 2-bit select code decides whether rails 3 and 4 are positive or negative. For a negative rail, the undervoltage and overvoltage roles of its two flags are exchanged. After its faults clear, each output is held asserted for a programmable number of cycles. A bypass input removes that hold.

Three controls override the normal behaviour:
- An overvoltage latch control can freeze the overvoltage output low. Raising the control clears it.
- A disable input forces both outputs inactive.
- A supply-lockout input forces undervoltage active and overvoltage inactive.

Top module: `rail_supervisor_seq`

## Requirements
- R1: A comparator flag changes the filtered state only after it has held its new value for `NCHK` consecutive rising edges. A pulse that lasts fewer edges has no effect on either output.
- R2: Rails 1 and 2 are positive. For them, `hi_below[0]`/`hi_below[1]` signal undervoltage and `lo_above[0]`/`lo_above[1]` signal overvoltage.
- R3: `pol_sel` selects the polarity of rails 3 and 4 (bit 2 is rail 3, bit 3 is rail 4):
  - 2'b00: both rails negative.
  - 2'b01: rail 3 positive, rail 4 negative.
  - 2'b10 or 2'b11: both rails positive.
  - For a negative rail, `hi_below` signals overvoltage and `lo_above` signals undervoltage.
- R4: Any undervoltage fault drives `uv_n` low at the `NCHK+1`-th rising edge after the raw flag changes.
- R5: After the last undervoltage fault clears, `uv_n` stays low for `hold_cycles` further edges.
  - `uv_n` rises at edge `NCHK+1+hold_cycles` after the raw flag clears.
  - A new fault during the hold restarts the wait.
  - `hold_cycles` is sampled when the countdown starts.
- R6: When `bypass` is high, or `hold_cycles` is 0, each output deasserts at the same edge at which its faults are seen cleared.
- R7: With `ov_clear` high, `ov_n` asserts on overvoltage faults and releases after the same hold as `uv_n`.
- R8: With `ov_clear` low, an asserted `ov_n` remains low after its faults clear. This also applies if `ov_clear` falls during a running hold. Raising `ov_clear` with no overvoltage fault releases `ov_n` at the next edge.
- R9: While `lockout` is high, `uv_n` is low and `ov_n` is high from the next edge on. After `lockout` falls, `uv_n` releases after the R5 hold.
- R10: While `dis` is high and `lockout` is low, both outputs are high from the next edge on. With `dis` high, `lockout` still pulls `uv_n` low, and `uv_n` rises at the edge after `lockout` falls.
- R11: During reset `uv_n` is low and `ov_n` is high. After reset with no faults, `uv_n` releases `hold_cycles+1` edges after the first edge out of reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hi_below | input | 4 | Per rail: high tap below threshold |
| lo_above | input | 4 | Per rail: low tap above threshold |
| pol_sel | input | 2 | Polarity code for rails 3 and 4 |
| hold_cycles | input | TW | Release hold length in cycles |
| bypass | input | 1 | Skip the release hold |
| ov_clear | input | 1 | High: overvoltage passes through with hold and clears a latch; low: overvoltage latches |
| dis | input | 1 | Force both outputs inactive |
| lockout | input | 1 | Supply lockout: force undervoltage, suppress overvoltage |
| uv_n | output | 1 | Undervoltage fault, active low |
| ov_n | output | 1 | Overvoltage fault, active low |

## Verification
Comparator flags go through the `NCHK`-sample filter and then the output register. A fault therefore appears `NCHK+1` edges after the flag changes, and a cleared fault releases `hold_cycles` edges later again. The control inputs `lockout`, `dis` and `ov_clear` act one edge after they change. The bench drives every input one time unit after a rising edge and samples there too. It advances an exact number of edges before each check, so it observes both the last edge before a predicted change and the edge at which the change lands. The polarity table holds each vector for five edges with the hold bypassed, so every mapping is checked in steady state.

// File: rtl/rail_supervisor_seq.sv
module rail_supervisor_seq #(
  parameter int NCHK = 3,
  parameter int TW = 16,
  parameter bit OV_LATCH_EN = 1'b1,
  parameter bit DIS_EN = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [3:0]    hi_below,
  input  logic [3:0]    lo_above,
  input  logic [1:0]    pol_sel,
  input  logic [TW-1:0] hold_cycles,
  input  logic          bypass,
  input  logic          ov_clear,
  input  logic          dis,
  input  logic          lockout,
  output logic          uv_n,
  output logic          ov_n
);
  localparam int NR = 4;
  localparam int NF = 2 * NR;
  localparam int CW = $clog2(NCHK + 1);

  logic [NF-1:0] raw, filt;
  assign raw = {lo_above, hi_below};

  for (genvar i = 0; i < NF; i++) begin : g_flt
    logic [CW-1:0] cnt;
    logic          f;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cnt <= '0;
        f   <= 1'b0;
      end else if (raw[i] == f) begin
        cnt <= '0;
      end else if (cnt == CW'(NCHK - 1)) begin
        f   <= raw[i];
        cnt <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
    assign filt[i] = f;
  end

  logic [NR-1:0] neg, hi_f, lo_f;
  assign neg  = {~pol_sel[1], pol_sel == 2'b00, 2'b00};
  assign hi_f = filt[NR-1:0];
  assign lo_f = filt[NF-1:NR];

  logic uv_any, ov_any, dis_act, latch_hold;
  assign uv_any     = |((hi_f & ~neg) | (lo_f & neg));
  assign ov_any     = |((lo_f & ~neg) | (hi_f & neg));
  assign dis_act    = DIS_EN && dis;
  assign latch_hold = OV_LATCH_EN && !ov_clear;

  logic          uv_asrt, uv_run;
  logic [TW-1:0] uv_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      uv_asrt <= 1'b1;
      uv_run  <= 1'b0;
      uv_cnt  <= '0;
    end else if (lockout) begin
      uv_asrt <= 1'b1;
      uv_run  <= 1'b0;
    end else if (dis_act) begin
      uv_asrt <= 1'b0;
      uv_run  <= 1'b0;
    end else if (uv_any) begin
      uv_asrt <= 1'b1;
      uv_run  <= 1'b0;
    end else if (uv_asrt) begin
      if (bypass || (!uv_run && hold_cycles == '0)) begin
        uv_asrt <= 1'b0;
        uv_run  <= 1'b0;
      end else if (!uv_run) begin
        uv_run <= 1'b1;
        uv_cnt <= hold_cycles;
      end else if (uv_cnt == TW'(1)) begin
        uv_asrt <= 1'b0;
        uv_run  <= 1'b0;
      end else begin
        uv_cnt <= uv_cnt - 1'b1;
      end
    end
  end

  logic          ov_asrt, ov_lat, ov_run;
  logic [TW-1:0] ov_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ov_asrt <= 1'b0;
      ov_lat  <= 1'b0;
      ov_run  <= 1'b0;
      ov_cnt  <= '0;
    end else if (lockout || dis_act) begin
      ov_asrt <= 1'b0;
      ov_lat  <= 1'b0;
      ov_run  <= 1'b0;
    end else if (ov_any) begin
      ov_asrt <= 1'b1;
      ov_run  <= 1'b0;
      if (latch_hold) ov_lat <= 1'b1;
    end else if (ov_asrt) begin
      if (latch_hold) begin
        ov_lat <= 1'b1;
        ov_run <= 1'b0;
      end else if (ov_lat || bypass || (!ov_run && hold_cycles == '0)) begin
        ov_asrt <= 1'b0;
        ov_lat  <= 1'b0;
        ov_run  <= 1'b0;
      end else if (!ov_run) begin
        ov_run <= 1'b1;
        ov_cnt <= hold_cycles;
      end else if (ov_cnt == TW'(1)) begin
        ov_asrt <= 1'b0;
        ov_run  <= 1'b0;
      end else begin
        ov_cnt <= ov_cnt - 1'b1;
      end
    end
  end

  assign uv_n = ~uv_asrt;
  assign ov_n = ~ov_asrt;

  p_uv_fault_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (uv_any && !lockout && !dis_act) |=> !uv_n);
  p_hold_run_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (uv_run || ov_run) |-> ((!uv_run || uv_cnt != '0) && (!ov_run || ov_cnt != '0)));
  p_bypass_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bypass && !uv_any && !lockout) |=> uv_n);
  p_ov_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ov_n) |-> $past(ov_any));
  p_latch_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!ov_n && latch_hold && !lockout && !dis_act) |=> !ov_n);
  p_lockout_r9: assert property (@(posedge clk) disable iff (!rst_n)
    lockout |=> (!uv_n && ov_n));
  p_disable_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (dis_act && !lockout) |=> (uv_n && ov_n));
endmodule

// File: tb/rail_supervisor_seq_test.sv
module rail_supervisor_seq_test;
  localparam int TW = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [3:0]    hi_below, lo_above;
  logic [1:0]    pol_sel;
  logic [TW-1:0] hold_cycles;
  logic          bypass, ov_clear, dis, lockout;
  logic          uv_n, ov_n;

  int  checks = 0;
  int  failures = 0;
  bit  done = 1'b0;

  always #10 clk = ~clk;

  rail_supervisor_seq #(.NCHK(3), .TW(TW)) uut (
    .clk(clk), .rst_n(rst_n), .hi_below(hi_below), .lo_above(lo_above),
    .pol_sel(pol_sel), .hold_cycles(hold_cycles), .bypass(bypass),
    .ov_clear(ov_clear), .dis(dis), .lockout(lockout), .uv_n(uv_n), .ov_n(ov_n)
  );

  // {hi_below, lo_above, pol_sel, expected uv_n, expected ov_n}
  localparam logic [11:0] VEC [12] = '{
    12'b0001_0000_10_0_1,
    12'b0000_0010_10_1_0,
    12'b0100_0000_10_0_1,
    12'b0100_0000_00_1_0,
    12'b0000_0100_00_0_1,
    12'b0100_0000_01_0_1,
    12'b1000_0000_01_1_0,
    12'b0000_1000_01_0_1,
    12'b1000_0000_11_0_1,
    12'b0000_1000_11_1_0,
    12'b0000_0000_00_1_1,
    12'b0001_0001_10_0_0
  };

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  initial begin
    rst_n = 1'b0; hi_below = '0; lo_above = '0; pol_sel = 2'b10;
    hold_cycles = 8'd5; bypass = 1'b0; ov_clear = 1'b1; dis = 1'b0; lockout = 1'b0;
    step(2);
    check("R11 uv_n in reset", uv_n, 1'b0);
    check("R11 ov_n in reset", ov_n, 1'b1);
    rst_n = 1'b1;
    step(5);
    check("R11 uv_n held after reset", uv_n, 1'b0);
    step(1);
    check("R11 uv_n released after reset", uv_n, 1'b1);

    bypass = 1'b1;
    for (int i = 0; i < 12; i++) begin
      hi_below = VEC[i][11:8];
      lo_above = VEC[i][7:4];
      pol_sel  = VEC[i][3:2];
      step(5);
      check($sformatf("R2/R3 vector %0d uv_n", i), uv_n, VEC[i][1]);
      check($sformatf("R2/R3 vector %0d ov_n", i), ov_n, VEC[i][0]);
    end
    hi_below = '0; lo_above = '0; pol_sel = 2'b10;
    step(5);

    // R1 short pulse ignored
    hi_below = 4'b0001; step(2);
    hi_below = 4'b0000; step(6);
    check("R1 two-edge pulse ignored", uv_n, 1'b1);
    // R4 latency
    hi_below = 4'b0001; step(3);
    check("R4 uv_n before filter settles", uv_n, 1'b1);
    step(1);
    check("R4 uv_n asserted at edge 4", uv_n, 1'b0);

    // R6 bypass release
    hi_below = 4'b0000; step(3);
    check("R6 bypass uv_n before release", uv_n, 1'b0);
    step(1);
    check("R6 bypass uv_n released", uv_n, 1'b1);
    // R6 zero hold
    hi_below = 4'b0001; step(5);
    bypass = 1'b0; hold_cycles = 8'd0;
    hi_below = 4'b0000; step(3);
    check("R6 zero hold uv_n before release", uv_n, 1'b0);
    step(1);
    check("R6 zero hold uv_n released", uv_n, 1'b1);
    hold_cycles = 8'd5;

    // R5 restart on new fault and hold sampled at start
    hi_below = 4'b0001; step(5);
    hi_below = 4'b0000; step(3);
    hi_below = 4'b0001; step(8);
    check("R5 restart keeps uv_n low", uv_n, 1'b0);
    hi_below = 4'b0000; step(5);
    hold_cycles = 8'd20; step(3);
    check("R5 uv_n held one edge before release", uv_n, 1'b0);
    step(1);
    check("R5 uv_n released after sampled hold", uv_n, 1'b1);
    hold_cycles = 8'd5;

    // R7 overvoltage timeout
    lo_above = 4'b0001; step(4);
    check("R7 ov_n asserted", ov_n, 1'b0);
    lo_above = 4'b0000; step(8);
    check("R7 ov_n held", ov_n, 1'b0);
    step(1);
    check("R7 ov_n released", ov_n, 1'b1);

    // R8 latch
    ov_clear = 1'b0;
    lo_above = 4'b0001; step(4);
    lo_above = 4'b0000; step(20);
    check("R8 ov_n latched", ov_n, 1'b0);
    ov_clear = 1'b1; step(1);
    check("R8 ov_n cleared", ov_n, 1'b1);
    lo_above = 4'b0001; step(4);
    lo_above = 4'b0000; step(6);
    ov_clear = 1'b0; step(6);
    check("R8 latch during hold", ov_n, 1'b0);
    ov_clear = 1'b1; step(1);
    check("R8 ov_n cleared after hold latch", ov_n, 1'b1);

    // R9 lockout
    lo_above = 4'b0001; step(4);
    check("R9 ov_n asserted before lockout", ov_n, 1'b0);
    lockout = 1'b1; lo_above = 4'b0000; step(1);
    check("R9 uv_n under lockout", uv_n, 1'b0);
    check("R9 ov_n under lockout", ov_n, 1'b1);
    step(5);
    lockout = 1'b0; step(5);
    check("R9 uv_n held after lockout", uv_n, 1'b0);
    step(1);
    check("R9 uv_n released after lockout", uv_n, 1'b1);

    // R10 disable
    dis = 1'b1; hi_below = 4'b0001; lo_above = 4'b0010; step(6);
    check("R10 uv_n disabled", uv_n, 1'b1);
    check("R10 ov_n disabled", ov_n, 1'b1);
    lockout = 1'b1; step(1);
    check("R10 lockout beats disable", uv_n, 1'b0);
    lockout = 1'b0; step(1);
    check("R10 uv_n released without hold", uv_n, 1'b1);
    dis = 1'b0; step(1);
    check("R10 uv_n after enable", uv_n, 1'b0);
    check("R10 ov_n after enable", ov_n, 1'b0);
    hi_below = '0; lo_above = '0;

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog all requirements actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule